// File: doc/BRIEF.md
# I2C Combined Random-Read Master

This block is the only master on an I2C bus. It reads one byte from a memory-style slave in a single transaction that software cannot split. A request gives it a 7-bit slave address and an 8-bit internal location. The block opens the bus with a start condition and writes the location to the slave in a write-addressed frame. It then turns the bus around with a repeated start rather than a stop. In a read-addressed frame it fetches one data byte, and then it closes the bus with a stop. Because the bus is never released between the location write and the data read, no other party can move the slave's internal pointer in between.

The block drives SCL and the pull-down of SDA. An output value of 1 means the line is released, so the external pull-up takes it high. The input `sda_in` is the level seen on the SDA wire. Bus timing comes from an internal step timer. Every bit time is split into four steps, and each step lasts `STEP_CYCLES` system clocks. A missing acknowledge from the slave stops the transfer at once. The block then closes the bus with a stop condition and reports which frame failed. At the end of every transaction, successful or not, `done` pulses for one cycle.

Top module: `i2c_rand_read_master`

## Requirements
- R1: After reset and whenever the block is idle, `scl_out` and `sda_out` are both 1, `busy` is 0 and `done` is 0. After reset, `err_code` and `rd_data` are 0.
- R2: A successful transaction puts this sequence on the bus, in order:
  - a start condition;
  - the byte {addr,0} and a slave acknowledge;
  - the location byte and a slave acknowledge;
  - a repeated start;
  - the byte {addr,1} and a slave acknowledge;
  - the data byte driven by the slave.
  Exactly two start conditions and exactly one stop occur per transaction, and the stop is the last bus event.
- R3: Bytes are sent and received most significant bit first. Within a data or acknowledge bit, SDA changes only while SCL is low, and SDA is sampled when SCL rises.
- R4: On success, `err_code` is 0 (none) when `done` pulses, and `rd_data` equals the byte the slave drove.
- R5: After the data byte, the master leaves SDA released (NACK, sampled as 1) during the ninth clock, and then issues the stop.
- R6: If the acknowledge after {addr,0} is sampled as 1, the block issues a stop without a repeated start, and `err_code` is 1.
- R7: If the acknowledge after the location byte is sampled as 1, the block issues a stop without a repeated start, and `err_code` is 2.
- R8: If the acknowledge after {addr,1} is sampled as 1, the block issues a stop, and `err_code` is 3.
- R9: While a transaction runs, every SCL low time and every SCL high time inside a transaction is exactly 2*STEP_CYCLES system clocks.
- R10: A request is taken only while `busy` is 0. A request raised during a transaction, whatever its address and location, changes neither the bus traffic nor the result. The address and location are captured in the cycle the request is taken.
- R11: `done` is high for exactly one cycle, in the first cycle that `busy` is 0 again. `err_code` and `rd_data` hold their values until the next request is taken. After an error, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request one random read (taken only while idle) |
| slv_addr | input | 7 | 7-bit slave address |
| mem_loc | input | 8 | Internal location to read |
| sda_in | input | 1 | Level sensed on the SDA wire |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_out | output | 1 | SDA drive: 0 pulls low, 1 releases |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err_code | output | 2 | 0 none, 1 address-write NACK, 2 location NACK, 3 address-read NACK |
| rd_data | output | 8 | Byte read from the slave, 0 after an error |

## Verification
The hardest case to reach from the ports is a transaction that fails late, after the repeated start. Reaching it needs a slave that acknowledges the write address and the location, and then refuses the read address. The bench builds this with a behavioural slave that watches start and stop conditions and counts SCL edges. That slave can be told to withhold any one of its three acknowledges. A transaction where `req` is raised again halfway through, with different address and location, shows that the captured request alone decides the traffic.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

    localparam int ADDR_BITS = 7;
    localparam int BYTE_BITS = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_BITS);
    localparam logic [1:0] LAST_STEP = 2'd3;

    // bus-level symbol executed by the engine, four steps each
    typedef enum logic [1:0] {
        SYM_START,
        SYM_RSTART,
        SYM_BIT,
        SYM_STOP
    } sym_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_ADDR_WR  = 2'd1,
        ERR_LOCATION = 2'd2,
        ERR_ADDR_RD  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        PH_ADDR_WR,
        PH_LOCATION,
        PH_ADDR_RD,
        PH_DATA
    } phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_BYTE,
        SQ_ACK,
        SQ_RSTART,
        SQ_STOP
    } sq_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    typedef struct packed {
        sq_e                  state;
        phase_e               phase;
        logic [BIT_IDX_W-1:0] bitcnt;
        logic [BYTE_BITS-1:0] sh;
        fault_e               fault;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        state:  SQ_IDLE,
        phase:  PH_ADDR_WR,
        bitcnt: '0,
        sh:     '0,
        fault:  ERR_NONE
    };

    // Line levels for step st of a symbol.  prev is the SDA level the master
    // held before the symbol began; it is kept through the SCL falling step.
    function automatic lines_t step_lines(sym_e s, logic [1:0] st, logic txb, logic prev);
        lines_t l;
        l.scl = st[1];
        unique case (s)
            SYM_START: begin
                l.scl = 1'b1;
                l.sda = ~st[1];
            end
            SYM_RSTART: l.sda = (st != LAST_STEP);
            SYM_BIT:    l.sda = (st == 2'd0) ? prev : txb;
            default:    l.sda = (st == 2'd0) ? prev : (st == LAST_STEP);
        endcase
        return l;
    endfunction

    function automatic fault_e phase_fault(phase_e p);
        unique case (p)
            PH_ADDR_WR:  return ERR_ADDR_WR;
            PH_LOCATION: return ERR_LOCATION;
            PH_ADDR_RD:  return ERR_ADDR_RD;
            default:     return ERR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rr_step_timer.sv
module rr_step_timer #(
    parameter int STEP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rr_symbol_engine.sv
module rr_symbol_engine
    import i2c_rr_pkg::*;
#(
    parameter int STEP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  sym_e sym_in,
    input  logic txb_in,
    input  logic sda_in,
    output logic scl_out,
    output logic sda_out,
    output logic sym_done,
    output logic rx_bit,
    output logic in_bit
);
    logic       active;
    logic       tick;
    logic [1:0] st;
    sym_e       sym_q;
    logic       txb_q;
    logic       prev_q;
    lines_t     first_lines;
    lines_t     next_lines;

    rr_step_timer #(.STEP_CYCLES(STEP_CYCLES)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (go),
        .run     (active),
        .tick    (tick)
    );

    assign sym_done = active && tick && (st == LAST_STEP);
    assign in_bit   = active && (sym_q == SYM_BIT);

    always_comb begin
        first_lines = step_lines(sym_in, 2'd0, txb_in, sda_out);
        next_lines  = step_lines(sym_q, st + 2'd1, txb_q, prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            st      <= 2'd0;
            sym_q   <= SYM_STOP;
            txb_q   <= 1'b1;
            prev_q  <= 1'b1;
            scl_out <= 1'b1;
            sda_out <= 1'b1;
            rx_bit  <= 1'b1;
        end else if (go) begin
            active  <= 1'b1;
            st      <= 2'd0;
            sym_q   <= sym_in;
            txb_q   <= txb_in;
            prev_q  <= sda_out;
            scl_out <= first_lines.scl;
            sda_out <= first_lines.sda;
        end else if (active && tick) begin
            if (st == LAST_STEP) begin
                active <= 1'b0;
            end else begin
                st      <= st + 2'd1;
                scl_out <= next_lines.scl;
                sda_out <= next_lines.sda;
                if (sym_q == SYM_BIT && st == 2'd1) begin
                    rx_bit <= sda_in;
                end
            end
        end
    end
endmodule

// File: rtl/rr_sequencer.sv
module rr_sequencer
    import i2c_rr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic [ADDR_BITS-1:0] slv_addr,
    input  logic [BYTE_BITS-1:0] mem_loc,
    input  logic                 sym_done,
    input  logic                 rx_bit,
    output logic                 go,
    output sym_e                 sym,
    output logic                 txb,
    output logic                 busy,
    output logic                 done,
    output fault_e               fault,
    output logic [BYTE_BITS-1:0] rd_data
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_BITS - 1);

    seq_t                 cur;
    seq_t                 nx;
    logic [ADDR_BITS-1:0] addr_q;
    logic [BYTE_BITS-1:0] loc_q;
    logic                 accept;
    logic                 capture;

    always_comb begin
        nx      = cur;
        go      = 1'b0;
        accept  = 1'b0;
        capture = 1'b0;
        if (cur.state == SQ_IDLE) begin
            if (req) begin
                accept    = 1'b1;
                go        = 1'b1;
                nx.state  = SQ_START;
                nx.phase  = PH_ADDR_WR;
                nx.bitcnt = '0;
                nx.sh     = {slv_addr, 1'b0};
                nx.fault  = ERR_NONE;
            end
        end else if (sym_done) begin
            go = 1'b1;
            unique case (cur.state)
                SQ_START, SQ_RSTART: begin
                    nx.state  = SQ_BYTE;
                    nx.bitcnt = '0;
                end
                SQ_BYTE: begin
                    nx.sh     = {cur.sh[BYTE_BITS-2:0], rx_bit};
                    nx.bitcnt = cur.bitcnt + BIT_IDX_W'(1);
                    if (cur.bitcnt == LAST_BIT) begin
                        nx.state = SQ_ACK;
                    end
                end
                SQ_ACK: begin
                    if (cur.phase != PH_DATA && rx_bit) begin
                        nx.fault = phase_fault(cur.phase);
                        nx.state = SQ_STOP;
                    end else begin
                        unique case (cur.phase)
                            PH_ADDR_WR: begin
                                nx.phase = PH_LOCATION;
                                nx.sh    = loc_q;
                                nx.state = SQ_BYTE;
                            end
                            PH_LOCATION: begin
                                nx.phase = PH_ADDR_RD;
                                nx.sh    = {addr_q, 1'b1};
                                nx.state = SQ_RSTART;
                            end
                            PH_ADDR_RD: begin
                                nx.phase = PH_DATA;
                                nx.state = SQ_BYTE;
                            end
                            default: begin
                                capture  = 1'b1;
                                nx.state = SQ_STOP;
                            end
                        endcase
                    end
                end
                default: begin
                    go       = 1'b0;
                    nx.state = SQ_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        unique case (nx.state)
            SQ_START:  sym = SYM_START;
            SQ_RSTART: sym = SYM_RSTART;
            SQ_STOP:   sym = SYM_STOP;
            default:   sym = SYM_BIT;
        endcase
        txb = (nx.state == SQ_BYTE && nx.phase != PH_DATA) ? nx.sh[BYTE_BITS-1] : 1'b1;
    end

    assign busy  = (cur.state != SQ_IDLE);
    assign fault = cur.fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= SEQ_RESET;
            addr_q  <= '0;
            loc_q   <= '0;
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            cur  <= nx;
            done <= (cur.state == SQ_STOP) && sym_done;
            if (accept) begin
                addr_q  <= slv_addr;
                loc_q   <= mem_loc;
                rd_data <= '0;
            end
            if (capture) begin
                rd_data <= cur.sh;
            end
        end
    end
endmodule

// File: rtl/i2c_rand_read_master.sv
module i2c_rand_read_master
    import i2c_rr_pkg::*;
#(
    parameter int STEP_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic [ADDR_BITS-1:0] slv_addr,
    input  logic [BYTE_BITS-1:0] mem_loc,
    input  logic                 sda_in,
    output logic                 scl_out,
    output logic                 sda_out,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           err_code,
    output logic [BYTE_BITS-1:0] rd_data
);
    logic   eng_go;
    sym_e   eng_sym;
    logic   eng_txb;
    logic   eng_done;
    logic   eng_rx;
    logic   bit_sym_active;
    fault_e fault;

    rr_sequencer i_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .slv_addr (slv_addr),
        .mem_loc  (mem_loc),
        .sym_done (eng_done),
        .rx_bit   (eng_rx),
        .go       (eng_go),
        .sym      (eng_sym),
        .txb      (eng_txb),
        .busy     (busy),
        .done     (done),
        .fault    (fault),
        .rd_data  (rd_data)
    );

    rr_symbol_engine #(.STEP_CYCLES(STEP_CYCLES)) i_eng (
        .clk      (clk),
        .rst      (rst),
        .go       (eng_go),
        .sym_in   (eng_sym),
        .txb_in   (eng_txb),
        .sda_in   (sda_in),
        .scl_out  (scl_out),
        .sda_out  (sda_out),
        .sym_done (eng_done),
        .rx_bit   (eng_rx),
        .in_bit   (bit_sym_active)
    );

    assign err_code = fault;
endmodule

// File: rtl/i2c_rr_checker.sv
module i2c_rr_checker (
    input logic clk,
    input logic rst,
    input logic req,
    input logic scl,
    input logic sda,
    input logic busy,
    input logic done,
    input logic in_bit
);
    // R3: no SDA movement while SCL stays high inside a data or acknowledge bit
    p_sda_stable_scl_high_r3: assert property (@(posedge clk) disable iff (rst)
        (in_bit && scl && $past(scl)) |-> $stable(sda));

    // R1: lines released whenever idle
    p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (scl && sda));

    // R11: done lasts one cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: done marks the first idle cycle after a transaction
    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R10: a transaction only begins from a request
    p_start_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req));
endmodule

bind i2c_rand_read_master i2c_rr_checker i_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .scl    (scl_out),
    .sda    (sda_out),
    .busy   (busy),
    .done   (done),
    .in_bit (bit_sym_active)
);

// File: tb/test_i2c_rand_read_master.sv
module test_i2c_rand_read_master;
    localparam int STEP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [6:0] slv_addr = '0;
    logic [7:0] mem_loc = '0;
    logic       scl_out, sda_out, busy, done;
    logic [1:0] err_code;
    logic [7:0] rd_data;
    logic       s_drv = 1'b0;
    wire        sda_bus = sda_out & ~s_drv;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    i2c_rand_read_master #(.STEP_CYCLES(STEP)) i_i2c_rand_read_master (
        .clk(clk), .rst(rst), .req(req), .slv_addr(slv_addr), .mem_loc(mem_loc),
        .sda_in(sda_bus), .scl_out(scl_out), .sda_out(sda_out), .busy(busy),
        .done(done), .err_code(err_code), .rd_data(rd_data)
    );

    function automatic logic [7:0] mem(input logic [7:0] x);
        return x * 8'd29 + 8'h4C;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural slave ----------------
    int         s_bit = 0;
    logic [7:0] s_sh = '0, s_dat = '0, s_loc = '0;
    logic       s_first = 1'b0, s_tx = 1'b0, s_sel = 1'b0, s_rw = 1'b0, s_acked = 1'b0;
    int         n_start = 0, n_stop = 0;
    logic [7:0] rec_w = '0, rec_loc = '0, rec_r = '0;
    logic       m_ack = 1'b0;
    logic [6:0] cfg_addr = '0;
    int         cfg_inj = 0;

    always @(negedge sda_bus) begin
        if (!rst && scl_out === 1'b1) begin
            n_start++;
            s_bit = 0; s_first = 1'b1; s_tx = 1'b0; s_drv = 1'b0;
        end
    end

    always @(posedge sda_bus) begin
        if (!rst && scl_out === 1'b1) begin
            n_stop++;
            s_tx = 1'b0; s_drv = 1'b0;
        end
    end

    always @(posedge scl_out) begin
        if (!rst) begin
            if (s_bit < 8) begin
                if (!s_tx) s_sh = {s_sh[6:0], sda_bus};
            end else if (s_bit == 8 && s_tx) begin
                m_ack = sda_bus;
            end
            s_bit++;
        end
    end

    always @(negedge scl_out) begin
        if (!rst) begin
            if (s_bit == 8) begin
                if (!s_tx) begin
                    if (s_first) begin
                        s_rw  = s_sh[0];
                        s_sel = (s_sh[7:1] == cfg_addr);
                        if (!s_sh[0]) rec_w = s_sh; else rec_r = s_sh;
                        s_acked = s_sel && !((cfg_inj == 1 && !s_sh[0]) || (cfg_inj == 3 && s_sh[0]));
                    end else begin
                        rec_loc = s_sh;
                        s_loc   = s_sh;
                        s_acked = s_sel && (cfg_inj != 2);
                    end
                    s_drv = s_acked;
                end else begin
                    s_drv = 1'b0;
                end
            end else if (s_bit == 9) begin
                s_bit = 0;
                s_drv = 1'b0;
                if (s_tx) begin
                    s_tx = 1'b0;
                end else if (s_first && s_rw && s_acked) begin
                    s_tx  = 1'b1;
                    s_dat = mem(s_loc);
                    s_drv = ~s_dat[7];
                end
                s_first = 1'b0;
            end else if (s_tx && s_bit >= 1 && s_bit <= 7) begin
                s_drv = ~s_dat[7 - s_bit];
            end
        end
    end

    // ---------------- SCL timing monitor (R9) ----------------
    logic mon_last = 1'b1;
    int   mon_run = 0, mon_runs = 0, mon_bad = 0;
    logic mon_idle = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (scl_out == mon_last) begin
                mon_run++;
                if (!busy) mon_idle = 1'b1;
            end else begin
                if (mon_last == 1'b0 || !mon_idle) begin
                    mon_runs++;
                    if (mon_run != 2 * STEP) mon_bad++;
                end
                mon_last = scl_out;
                mon_run  = 1;
                mon_idle = !busy;
            end
        end
    end

    // ---------------- transaction task ----------------
    task automatic run_txn(input logic [6:0] addr, input logic [7:0] loc, input int inj,
                           input logic [6:0] dev_addr, input logic poke);
        int exp_err;
        int exp_starts;
        int t;
        logic [7:0] exp_data;
        string etag;
        cfg_addr = dev_addr; cfg_inj = inj;
        n_start = 0; n_stop = 0; rec_w = '0; rec_loc = '0; rec_r = '0; m_ack = 1'b0;
        exp_err    = (dev_addr != addr) ? 1 : inj;
        exp_starts = (exp_err == 1 || exp_err == 2) ? 1 : 2;
        exp_data   = (exp_err == 0) ? mem(loc) : 8'h00;
        etag = (exp_err == 0) ? "R4 err_code" : (exp_err == 1) ? "R6 err_code" :
               (exp_err == 2) ? "R7 err_code" : "R8 err_code";
        @(negedge clk);
        slv_addr = addr; mem_loc = loc; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            slv_addr = ~addr; mem_loc = ~loc; req = 1'b1;
            @(negedge clk);
            req = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(done, "R11 done seen", done, 1);
        check(err_code == exp_err[1:0], etag, err_code, exp_err);
        check(rd_data == exp_data, exp_err == 0 ? (poke ? "R10 rd_data" : "R4 rd_data") : "R11 rd_data",
              rd_data, exp_data);
        check(n_stop == 1, "R2 stop count", n_stop, 1);
        check(n_start == exp_starts, exp_err == 0 ? "R2 start count" : "R6 start count",
              n_start, exp_starts);
        check(rec_w == {addr, 1'b0}, "R3 write address byte", rec_w, {addr, 1'b0});
        if (exp_err != 1) check(rec_loc == loc, "R3 location byte", rec_loc, loc);
        if (exp_err == 0 || exp_err == 3)
            check(rec_r == {addr, 1'b1}, "R2 read address byte", rec_r, {addr, 1'b1});
        if (exp_err == 0) check(m_ack == 1'b1, "R5 master nack", m_ack, 1);
        check(scl_out && sda_out && !busy, "R1 released at done", {scl_out, sda_out, busy}, 3'b110);
        @(negedge clk);
        check(!done, "R11 done one cycle", done, 0);
        check(rd_data == exp_data && err_code == exp_err[1:0], "R11 result held",
              {err_code, rd_data}, {exp_err[1:0], exp_data});
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(scl_out && sda_out, "R1 reset lines", {scl_out, sda_out}, 2'b11);
        check(!busy && !done, "R1 reset busy/done", {busy, done}, 2'b00);
        check(err_code == 2'd0 && rd_data == 8'h00, "R1 reset result", {err_code, rd_data}, 0);

        // every location at one address
        for (int l = 0; l < 256; l++) run_txn(7'h50, 8'(l), 0, 7'h50, 1'b0);
        // spread of addresses
        for (int a = 0; a < 128; a += 4) run_txn(7'(a), 8'(a * 3 + 1), 0, 7'(a), 1'b0);
        // NACK in each phase, then a clean recovery
        for (int k = 1; k <= 3; k++) begin
            run_txn(7'h2A, 8'hC3, k, 7'h2A, 1'b0);
            run_txn(7'h2A, 8'h3C, 0, 7'h2A, 1'b0);
        end
        run_txn(7'h11, 8'h80, 0, 7'h12, 1'b0);   // no device at this address
        run_txn(7'h7F, 8'hFF, 2, 7'h7F, 1'b0);
        run_txn(7'h00, 8'h00, 3, 7'h00, 1'b0);
        // request during a transaction must not disturb it
        run_txn(7'h35, 8'h96, 0, 7'h35, 1'b1);
        run_txn(7'h35, 8'h69, 1, 7'h35, 1'b1);

        check(mon_runs > 0, "R9 scl phases measured", mon_runs, 1);
        check(mon_bad == 0, "R9 scl phase length", mon_bad, 0);
        summary();
        $finish;
    end
endmodule